// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog with three 32-bit registers: control, config and mode. Software arms it with one keyed write to the mode register. That write carries a 4-bit interval code and an enable bit. Once armed, software must restart the countdown in time, using a control write that carries a second key. Any write without the correct key changes nothing.

A prescaler turns the core clock into a one-millisecond tick. The countdown counts these ticks against the timeout that the interval code selects. When the countdown expires, the block does what the config register asks. It can raise a system reset pulse of fixed width, or set a sticky interrupt flag, or both. While the watchdog stays enabled, the countdown then reloads by itself and runs again.

The register port is a single-cycle port. A write takes effect at the clock edge where it is sampled. Read data is combinational from the address.

Top module: `kwdt_top`

## Requirements
- R1: After reset the watchdog is disabled, the interval code is 0, the config action field is 1, no interrupt is pending, and both `sys_rst_o` and `irq_o` are low.
- R2: A write to the mode register (offset 0x18) or the config register (offset 0x14) takes effect only when bits [31:16] hold 0x16AA. A write with any other key leaves every register unchanged.
- R3: Reads behave as follows:
  - Control (0x10) always reads zero.
  - Config (0x14) returns the action field in bits [1:0] and the pending interrupt flag in bit 8.
  - Mode (0x18) returns the interval code in bits [7:4] and the enable bit in bit 0.
  - Key fields and unmapped offsets read as zero.
- R4: Interval codes select these timeouts in milliseconds:
  - Code 0: 500.
  - Codes 1 to 6: the code times 1000.
  - Codes 7 to 11: 8000, 10000, 12000, 14000, 16000.
  - Codes 12 to 15: 16000.
- R5: A keyed mode write with bit 0 set enables the watchdog and loads the selected timeout. Expiry occurs exactly timeout × `TICK_CYC` clock edges after the edge that sampled the write.
- R6: A restart is a control write with bit 0 = 1 and bits [12:1] = 0xA57. While the watchdog is enabled, a restart reloads the full timeout, counted from its own edge. A control write with a wrong key or with bit 0 clear has no effect.
- R7: A keyed mode write with bit 0 clear stops the countdown, so no expiry follows. A restart is ignored while the watchdog is disabled.
- R8: When config bit 0 is set, an expiry drives `sys_rst_o` high for exactly `RST_CYC` cycles, starting right after the expiry edge. Action value 1 does not set the interrupt.
- R9: When config bit 1 is set, an expiry sets a sticky interrupt flag on `irq_o`, and action value 2 gives no reset pulse. The flag stays set until a keyed config write with bit 8 = 1 clears it. A keyed config write with bit 8 = 0 leaves the flag set.
- R10: While the watchdog stays enabled, the countdown reloads after each expiry. The next expiry follows one full timeout later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sys_rst_o | output | 1 | System reset pulse on expiry |
| irq_o | output | 1 | Sticky expiry interrupt |

## Verification
The assertions take these things for granted about the inputs:
- Every register-port input is known (not X) whenever reset is released.
- At most one access occurs per cycle.
- `RST_CYC` is shorter than the shortest timeout, so one reset pulse always ends before the next expiry.

The stimulus keeps within these limits. It drives every port input away from the rising edge. Each write is held for exactly one sampled edge. The bench waits for each reset pulse to finish before it rearms or reconfigures the block.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam int unsigned WORD_W = 32;
   // register offsets, decoded by the bus neighbour
   localparam logic [7:0] OFS_CTL  = 8'h10;
   localparam logic [7:0] OFS_CFG  = 8'h14;
   localparam logic [7:0] OFS_MODE = 8'h18;
   // access keys
   localparam logic [11:0] KICK_KEY = 12'hA57;
   localparam logic [15:0] GATE_KEY = 16'h16AA;
   // field positions
   localparam int unsigned ACT_RST_BIT = 0;
   localparam int unsigned ACT_IRQ_BIT = 1;
   localparam int unsigned CLR_BIT     = 8;
   // longest timeout in ticks
   localparam int unsigned MS_MAX = 16000;
   localparam int unsigned MS_MIN = 500;
   localparam int unsigned CNT_W  = $clog2(MS_MAX + 1);
   typedef logic [1:0] act_t;
   typedef logic [3:0] code_t;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              irq_set,
   output logic [WORD_W-1:0] rdata,
   output logic              en,
   output code_t             code,
   output code_t             code_nx,
   output act_t              act,
   output logic              pend,
   output logic              arm,
   output logic              kick
);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

   logic wr, gate_ok, cfg_wr, kick_ok;
   wire  unused_bits = ^wdata[15:13];

   assign wr      = sel & we;
   assign gate_ok = (wdata[31:16] == GATE_KEY);
   assign arm     = wr & (addr == A_MODE) & gate_ok;
   assign cfg_wr  = wr & (addr == A_CFG) & gate_ok;
   assign kick_ok = wdata[0] & (wdata[12:1] == KICK_KEY);
   assign kick    = wr & (addr == A_CTL) & kick_ok & en;
   assign code_nx = arm ? wdata[7:4] : code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         code <= '0;
      end else if (arm) begin
         en   <= wdata[0];
         code <= wdata[7:4];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= act_t'(1);
      end else if (cfg_wr) begin
         act <= wdata[1:0];
      end
   end

   // set wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (irq_set) begin
         pend <= 1'b1;
      end else if (cfg_wr && wdata[CLR_BIT]) begin
         pend <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_MODE) begin
         rdata[7:4] = code;
         rdata[0]   = en;
      end else if (addr == A_CFG) begin
         rdata[CLR_BIT] = pend;
         rdata[1:0]     = act;
      end
   end
endmodule

// File: rtl/kwdt_decode.sv
module kwdt_decode
   import kwdt_pkg::*;
(
   input  code_t            code,
   output logic [CNT_W-1:0] ticks
);
   int unsigned ms;
   always_comb begin
      if (code == 4'd0) begin
         ms = MS_MIN;
      end else if (code <= 4'd6) begin
         ms = 1000 * int'(code);
      end else if (code <= 4'd11) begin
         ms = 2000 * (int'(code) - 3);
      end else begin
         ms = MS_MAX;
      end
      ticks = CNT_W'(ms);
   end
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
   parameter int unsigned TICK_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   generate
      if (TICK_CYC == 1) begin : g_direct
         wire unused_ctl = clk ^ rst_n ^ clr;
         assign tick = run;
      end else begin : g_div
         localparam int unsigned PW = $clog2(TICK_CYC);
         localparam logic [PW-1:0] LAST = PW'(TICK_CYC - 1);
         logic [PW-1:0] pre;
         assign tick = run & (pre == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre <= '0;
            end else if (clr || !run || tick) begin
               pre <= '0;
            end else begin
               pre <= pre + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
   import kwdt_pkg::*;
#(
   parameter int unsigned RST_CYC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  act_t             act,
   output logic             irq_set,
   output logic             rst_pulse
);
   logic [CNT_W-1:0] cnt;
   logic             expire;

   assign expire  = en & tick & ~load & (cnt == CNT_W'(1));
   assign irq_set = expire & act[ACT_IRQ_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (en && tick) begin
         cnt <= (cnt == CNT_W'(1)) ? load_val : cnt - 1'b1;
      end
   end

   generate
      if (RST_CYC == 1) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_pulse <= 1'b0;
            else        rst_pulse <= expire & act[ACT_RST_BIT];
         end
      end else begin : g_stretch
         localparam int unsigned RW = $clog2(RST_CYC + 1);
         logic [RW-1:0] rcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rcnt <= '0;
            end else if (expire && act[ACT_RST_BIT]) begin
               rcnt <= RW'(RST_CYC);
            end else if (rcnt != '0) begin
               rcnt <= rcnt - 1'b1;
            end
         end
         assign rst_pulse = (rcnt != '0);
      end
   endgenerate
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned TICK_CYC = 1000,
   parameter int unsigned RST_CYC  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              sys_rst_o,
   output logic              irq_o
);
   initial begin
      assert (ADDR_W >= 5 && ADDR_W <= 32) else $fatal(1, "ADDR_W out of range");
      assert (TICK_CYC >= 1) else $fatal(1, "TICK_CYC must be at least 1");
      assert (RST_CYC >= 1 && RST_CYC < MS_MIN * TICK_CYC)
         else $fatal(1, "RST_CYC must be shorter than the shortest timeout");
   end

   logic             en_w, pend_w, arm_w, kick_w, tick_w, irq_set_w;
   code_t            code_w, code_nx_w;
   act_t             act_w;
   logic [CNT_W-1:0] load_val_w;

   kwdt_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we),
      .addr(bus_addr), .wdata(bus_wdata), .irq_set(irq_set_w),
      .rdata(bus_rdata), .en(en_w), .code(code_w), .code_nx(code_nx_w),
      .act(act_w), .pend(pend_w), .arm(arm_w), .kick(kick_w)
   );

   kwdt_decode u_dec (.code(code_nx_w), .ticks(load_val_w));

   kwdt_prescale #(.TICK_CYC(TICK_CYC)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(en_w), .clr(arm_w | kick_w), .tick(tick_w)
   );

   kwdt_count #(.RST_CYC(RST_CYC)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en_w), .load(arm_w | kick_w),
      .load_val(load_val_w), .tick(tick_w), .act(act_w),
      .irq_set(irq_set_w), .rst_pulse(sys_rst_o)
   );

   assign irq_o = pend_w;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
   import kwdt_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned RST_CYC = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              sys_rst_o,
   input logic              irq_o,
   input logic              en,
   input code_t             code,
   input act_t              act
);
   wire unused_data = ^{bus_wdata[15:9], bus_wdata[7:0]};

   logic bad_mode, bad_cfg, clr_wr, ctl_rd;
   assign bad_mode = bus_sel & bus_we & (bus_addr == ADDR_W'(OFS_MODE)) & (bus_wdata[31:16] != GATE_KEY);
   assign bad_cfg  = bus_sel & bus_we & (bus_addr == ADDR_W'(OFS_CFG)) & (bus_wdata[31:16] != GATE_KEY);
   assign clr_wr   = bus_sel & bus_we & (bus_addr == ADDR_W'(OFS_CFG)) & (bus_wdata[31:16] == GATE_KEY) & bus_wdata[CLR_BIT];
   assign ctl_rd   = bus_sel & ~bus_we & (bus_addr == ADDR_W'(OFS_CTL));

   int unsigned run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_len <= 0;
      else if (sys_rst_o) run_len <= run_len + 1;
      else                run_len <= 0;
   end

   AST_BADKEY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      bad_mode |=> ($stable(en) && $stable(code))); // R2
   AST_BADKEY_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      bad_cfg |=> $stable(act)); // R2
   AST_CTL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd |-> (bus_rdata == 32'd0)); // R3
   AST_EXPIRY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sys_rst_o) || $rose(irq_o)) |-> $past(en)); // R7
   AST_RESET_NEEDS_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> $past(act[ACT_RST_BIT])); // R8
   AST_RESET_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst_o) |-> (run_len == RST_CYC)); // R8
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_wr) |=> irq_o); // R9
endmodule

bind kwdt_top kwdt_chk #(.ADDR_W(ADDR_W), .RST_CYC(RST_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .sys_rst_o(sys_rst_o), .irq_o(irq_o), .en(en_w), .code(code_w), .act(act_w)
);

// File: tb/sim_kwdt_top.sv
module sim_kwdt_top;
   localparam int CLK_PERIOD = 10;
   localparam int TICK = 2;
   localparam int RSTC = 4;
   localparam logic [7:0] A_CTL = 8'h10, A_CFG = 8'h14, A_MODE = 8'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sys_rst_o, irq_o;

   int checks = 0, fails = 0;
   int cyc = 0;
   int last_wr = 0;
   bit done = 0;
   bit watch_on = 0;
   int rst_seen = 0;

   kwdt_top #(.ADDR_W(8), .TICK_CYC(TICK), .RST_CYC(RSTC)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sys_rst_o(sys_rst_o), .irq_o(irq_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (watch_on && sys_rst_o) rst_seen <= rst_seen + 1;

   function automatic int ms_of(input int c);
      if (c == 0) return 500;
      if (c <= 6) return c * 1000;
      case (c)
         7: return 8000;
         8: return 10000;
         9: return 12000;
         10: return 14000;
         default: return 16000;
      endcase
   endfunction

   function automatic logic [31:0] mw(input logic e, input logic [3:0] c);
      return {16'h16AA, 8'h00, c, 3'b000, e};
   endfunction
   function automatic logic [31:0] cw(input logic clr, input logic [1:0] a);
      return {16'h16AA, 7'b0, clr, 6'b0, a};
   endfunction
   localparam logic [31:0] KICK = {19'b0, 12'hA57, 1'b1};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
      last_wr = cyc;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic wait_edge(input int e);
      while (cyc < e) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 rst_o", {31'b0, sys_rst_o}, 0);
      chk("R1 irq_o", {31'b0, irq_o}, 0);
      rd(A_MODE, v); chk("R1 mode", v, 0);
      rd(A_CFG, v);  chk("R1 cfg", v, 1);
      rd(A_CTL, v);  chk("R3 ctl", v, 0);
   endtask

   task automatic t_keys();
      logic [31:0] v;
      wr(A_MODE, {16'h1234, 16'h0051});
      rd(A_MODE, v); chk("R2 mode bad key", v, 0);
      wr(A_CFG, {16'h16AB, 16'h0002});
      rd(A_CFG, v); chk("R2 cfg bad key", v, 1);
      wr(A_MODE, mw(1'b0, 4'd9));
      rd(A_MODE, v); chk("R3 mode readback", v, 32'h90);
      rd(8'h00, v); chk("R3 unmapped", v, 0);
      wr(A_MODE, mw(1'b0, 4'd0));
   endtask

   task automatic t_period(input int c);
      int e0, n;
      wr(A_MODE, mw(1'b1, 4'(c)));
      e0 = last_wr;
      n = ms_of(c) * TICK;
      wait_edge(e0 + n - 1); chk($sformatf("R4 code %0d early", c), {31'b0, sys_rst_o}, 0);
      wait_edge(e0 + n);     chk($sformatf("R5 code %0d expiry", c), {31'b0, sys_rst_o}, 1);
      for (int k = 1; k < RSTC; k++) begin
         wait_edge(e0 + n + k); chk("R8 pulse high", {31'b0, sys_rst_o}, 1);
      end
      wait_edge(e0 + n + RSTC); chk("R8 pulse end", {31'b0, sys_rst_o}, 0);
      chk("R8 no irq", {31'b0, irq_o}, 0);
      wr(A_MODE, mw(1'b0, 4'd0));
   endtask

   task automatic t_kick();
      int e0, e1;
      wr(A_MODE, mw(1'b1, 4'd0));
      e0 = last_wr;
      wait_edge(e0 + 300);
      wr(A_CTL, {19'b0, 12'hA56, 1'b1});
      wr(A_CTL, {19'b0, 12'hA57, 1'b0});
      wait_edge(e0 + 600);
      wr(A_CTL, KICK);
      e1 = last_wr;
      wait_edge(e0 + 1000); chk("R6 old deadline", {31'b0, sys_rst_o}, 0);
      wait_edge(e1 + 999);  chk("R6 bad kicks ignored", {31'b0, sys_rst_o}, 0);
      wait_edge(e1 + 1000); chk("R6 restart expiry", {31'b0, sys_rst_o}, 1);
      wr(A_MODE, mw(1'b0, 4'd0));
      wait_edge(e1 + 1000 + RSTC + 1);
   endtask

   task automatic t_disable();
      int e0;
      logic [31:0] v;
      wr(A_MODE, mw(1'b1, 4'd0));
      e0 = last_wr;
      rst_seen = 0; watch_on = 1;
      wait_edge(e0 + 500);
      wr(A_MODE, mw(1'b0, 4'd0));
      wr(A_CTL, KICK);
      wait_edge(e0 + 3000);
      watch_on = 0;
      chk("R7 no expiry when stopped", rst_seen, 0);
      rd(A_MODE, v); chk("R7 mode disabled", v, 0);
   endtask

   task automatic t_irq();
      int e0;
      logic [31:0] v;
      wr(A_CFG, cw(1'b0, 2'd2));
      rd(A_CFG, v); chk("R3 cfg readback", v, 2);
      wr(A_MODE, mw(1'b1, 4'd0));
      e0 = last_wr;
      rst_seen = 0; watch_on = 1;
      wait_edge(e0 + 999);  chk("R9 irq early", {31'b0, irq_o}, 0);
      wait_edge(e0 + 1000); chk("R9 irq set", {31'b0, irq_o}, 1);
      wait_edge(e0 + 1010); chk("R9 irq sticky", {31'b0, irq_o}, 1);
      rd(A_CFG, v); chk("R3 cfg pending", v, 32'h102);
      wr(A_CFG, cw(1'b0, 2'd2));
      chk("R9 no clear without bit 8", {31'b0, irq_o}, 1);
      wr(A_CFG, cw(1'b1, 2'd2));
      chk("R9 clear", {31'b0, irq_o}, 0);
      wait_edge(e0 + 1999); chk("R10 reload early", {31'b0, irq_o}, 0);
      wait_edge(e0 + 2000); chk("R10 periodic expiry", {31'b0, irq_o}, 1);
      watch_on = 0;
      chk("R9 no reset pulse", rst_seen, 0);
      wr(A_MODE, mw(1'b0, 4'd0));
      wr(A_CFG, cw(1'b1, 2'd1));
      chk("R9 cleared at end", {31'b0, irq_o}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_keys();
      t_period(0);
      t_period(3);
      t_period(7);
      t_period(12);
      t_period(15);
      t_kick();
      t_disable();
      t_irq();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule